// File: doc/BRIEF.md
# Tick-compare soft-interrupt register unit

This unit holds the timer and soft-interrupt state of one processor strand. A 63-bit system tick counter advances once per clock. Two compare registers are set beside it, one for the supervisor and one for the hypervisor. When the count equals an armed compare value, the unit sets bit 16 of the soft-interrupt register (supervisor) or the hypervisor pending flag. In either case it pulses `recheck_o` so that the interrupt logic looks at its inputs again.

Software reaches every register through one index-addressed port. A request is one cycle of `req_valid_i` carrying a write flag, a 5-bit index and 64-bit data. Read data, the read strobe and the error flag come back one cycle later from registers. Besides the timer state, the unit holds:
- set and clear aliases of the soft-interrupt register,
- a 4-bit priority level,
- an interrupt-enable bit,
- a read-only version word,
- a trap base address with its low bits masked,
- a hypervisor state word whose id bit is pinned to 1.

Register indices: 0 tick, 1 supervisor compare, 2 hypervisor compare, 3 soft-interrupt, 4 soft-interrupt set alias, 5 soft-interrupt clear alias, 6 priority level, 7 state (enable at bit 1), 8 hypervisor pending, 9 version, 10 trap base, 11 hypervisor state. Indices 12 to 31 are unimplemented.

Top module: `tick_irq_regs`

## Requirements
- R1: The tick counter (index 0) adds one every clock. A write loads it. A read returns the count held at the clock edge that takes the request.
- R2: An armed supervisor compare (index 1) whose bits 62:0 equal the count sets soft-interrupt bit 16 and pulses `recheck_o`, both one cycle after the equality. It then disarms, so each arming fires at most once.
- R3: An armed hypervisor compare (index 2) whose bits 62:0 equal the count writes the pending flag (index 8) to 1 and pulses `recheck_o` one cycle later.
- R4: A compare write with bit 63 set never fires, and it cancels a match that is already armed.
- R5: A compare write arms only if bit 63 is clear and bits 62:0 are strictly greater than the count at the write edge. A value not above the count never fires, even after the count is later loaded lower.
- R6: A write to index 4 ORs the data into the soft-interrupt register. A write to index 5 clears each bit that is 1 in the data. A write to index 3 loads it. Each of these three writes pulses `recheck_o`. Reads of indices 3, 4 and 5 return the register.
- R7: A write to index 7 that takes the enable bit (bit 1) from 0 to 1 pulses `recheck_o`. Other index-7 writes do not.
- R8: A write to the priority level (index 6, bits 3:0) with a value below the current level pulses `recheck_o`. Equal or higher values do not.
- R9: Index 9 reads 0x030608: window count 8 in bits 7:0, max trap level 6 in bits 15:8, max global level 3 in bits 23:16. A write to it asserts `err_o` and changes nothing.
- R10: The trap base (index 10) reads with bits 14:0 zero, whatever was written.
- R11: The hypervisor state (index 11, 16 bits) always reads with its id bit (bit 11) set, both after reset and after any write.
- R12: A read or write of index 12 to 31 asserts `err_o` for one cycle and leaves all state unchanged.
- R13: After reset the following are zero: soft-interrupt, priority level, enable, pending, `recheck_o` and `err_o`. Both compares reset disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access request this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_idx_i | input | 5 | Register index |
| req_wdata_i | input | 64 | Write data |
| rdata_o | output | 64 | Read data, one cycle after a read |
| rvalid_o | output | 1 | Read data valid |
| err_o | output | 1 | Access error, one cycle pulse |
| recheck_o | output | 1 | Interrupt re-evaluation pulse |
| softint_o | output | 17 | Soft-interrupt register |
| hpend_o | output | 1 | Hypervisor pending flag |
| pil_o | output | 4 | Priority level |
| ie_o | output | 1 | Interrupt enable |

## Verification
The hardest case to reach is a compare match at an exact, known cycle. The count runs freely and would take ages to reach an arbitrary value. The bench therefore loads the counter through index 0 and writes the compare on the very next edge. This fixes the count at the arming edge and gives the cycle where bit 16 or the pending flag must rise. The same reload trick lets the bench check the arming rule. It writes a compare equal to the count, then loads the count a few steps lower, so an unarmed value passes under the counter and must stay silent. Cancel and disable are checked the same way: with an armed or disabled compare in front of the count, the bench waits well past the match point and watches the outputs stay low.

// File: rtl/tirq_pkg.sv
package tirq_pkg;
  typedef enum logic [4:0] {
    IDX_TICK   = 5'd0,
    IDX_SCMP   = 5'd1,
    IDX_HCMP   = 5'd2,
    IDX_SOFT   = 5'd3,
    IDX_SSET   = 5'd4,
    IDX_SCLR   = 5'd5,
    IDX_PIL    = 5'd6,
    IDX_STATE  = 5'd7,
    IDX_HPEND  = 5'd8,
    IDX_HVER   = 5'd9,
    IDX_HTBA   = 5'd10,
    IDX_HSTATE = 5'd11
  } reg_idx_e;

  localparam int unsigned NUM_CMP = 2;
  localparam int unsigned CMP_SUP = 0;
  localparam int unsigned CMP_HYP = 1;
endpackage

// File: rtl/tirq_cmp.sv
module tirq_cmp #(
  parameter int unsigned CNT_W = 63
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_i,
  input  logic [CNT_W:0] wdata_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W:0] cmp_o,
  output logic           hit_o
);
  logic [CNT_W:0] cmp_q;
  logic           armed_q;

  assign hit_o = armed_q && (cmp_q[CNT_W-1:0] == cnt_i);
  assign cmp_o = cmp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q   <= {1'b1, {CNT_W{1'b0}}};
      armed_q <= 1'b0;
    end else if (wr_i) begin
      cmp_q   <= wdata_i;
      // arm only for a future, enabled value
      armed_q <= !wdata_i[CNT_W] && (wdata_i[CNT_W-1:0] > cnt_i);
    end else if (hit_o) begin
      armed_q <= 1'b0;
    end
  end
endmodule

// File: rtl/tirq_soft.sv
module tirq_soft #(
  parameter int unsigned SOFT_W    = 17,
  parameter int unsigned MATCH_BIT = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_load_i,
  input  logic              wr_set_i,
  input  logic              wr_clr_i,
  input  logic [SOFT_W-1:0] wdata_i,
  input  logic              match_i,
  output logic [SOFT_W-1:0] soft_o
);
  logic [SOFT_W-1:0] soft_q, soft_d;

  always_comb begin
    soft_d = soft_q;
    if (wr_load_i)     soft_d = wdata_i;
    else if (wr_set_i) soft_d = soft_q | wdata_i;
    else if (wr_clr_i) soft_d = soft_q & ~wdata_i;
    if (match_i) soft_d[MATCH_BIT] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) soft_q <= '0;
    else         soft_q <= soft_d;
  end

  assign soft_o = soft_q;
endmodule

// File: rtl/tirq_priv.sv
module tirq_priv #(
  parameter int unsigned PIL_W    = 4,
  parameter int unsigned HTBA_W   = 49,
  parameter int unsigned HST_W    = 16,
  parameter int unsigned HST_ID   = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_pil_i,
  input  logic              wr_state_i,
  input  logic              wr_hpend_i,
  input  logic              wr_htba_i,
  input  logic              wr_hstate_i,
  input  logic [PIL_W-1:0]  pil_wdata_i,
  input  logic              ie_wdata_i,
  input  logic              hpend_wdata_i,
  input  logic [HTBA_W-1:0] htba_wdata_i,
  input  logic [HST_W-1:0]  hst_wdata_i,
  input  logic              hmatch_i,
  output logic [PIL_W-1:0]  pil_o,
  output logic              ie_o,
  output logic              hpend_o,
  output logic [HTBA_W-1:0] htba_o,
  output logic [HST_W-1:0]  hst_o,
  output logic              ie_rise_o,
  output logic              pil_drop_o
);
  localparam logic [HST_W-1:0] HST_ID_MASK = HST_W'(1) << HST_ID;

  logic [PIL_W-1:0]  pil_q;
  logic              ie_q;
  logic              hpend_q;
  logic [HTBA_W-1:0] htba_q;
  logic [HST_W-1:0]  hst_q;

  assign ie_rise_o  = wr_state_i && ie_wdata_i && !ie_q;
  assign pil_drop_o = wr_pil_i && (pil_wdata_i < pil_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pil_q   <= '0;
      ie_q    <= 1'b0;
      hpend_q <= 1'b0;
      htba_q  <= '0;
      hst_q   <= HST_ID_MASK;
    end else begin
      if (wr_pil_i)    pil_q  <= pil_wdata_i;
      if (wr_state_i)  ie_q   <= ie_wdata_i;
      if (wr_htba_i)   htba_q <= htba_wdata_i;
      if (wr_hstate_i) hst_q  <= hst_wdata_i | HST_ID_MASK;
      if (hmatch_i)        hpend_q <= 1'b1;
      else if (wr_hpend_i) hpend_q <= hpend_wdata_i;
    end
  end

  assign pil_o   = pil_q;
  assign ie_o    = ie_q;
  assign hpend_o = hpend_q;
  assign htba_o  = htba_q;
  assign hst_o   = hst_q;
endmodule

// File: rtl/tick_irq_regs.sv
module tick_irq_regs
  import tirq_pkg::*;
#(
  parameter int unsigned DATA_W    = 64,
  parameter int unsigned SOFT_W    = 17,
  parameter int unsigned MATCH_BIT = 16,
  parameter int unsigned PIL_W     = 4,
  parameter int unsigned IE_BIT    = 1,
  parameter int unsigned HTBA_LSB  = 15,
  parameter int unsigned HST_W     = 16,
  parameter int unsigned HST_ID    = 11,
  parameter logic [7:0]  NWIN      = 8'd8,
  parameter logic [7:0]  MAX_TL    = 8'd6,
  parameter logic [7:0]  MAX_GL    = 8'd3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [4:0]        req_idx_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic              err_o,
  output logic              recheck_o,
  output logic [SOFT_W-1:0] softint_o,
  output logic              hpend_o,
  output logic [PIL_W-1:0]  pil_o,
  output logic              ie_o
);
  localparam int unsigned CNT_W  = DATA_W - 1;
  localparam int unsigned HTBA_W = DATA_W - HTBA_LSB;
  localparam logic [DATA_W-1:0] HVER_VAL = DATA_W'({MAX_GL, MAX_TL, NWIN});

  logic             idx_ok;
  logic             wr_ok, rd_ok;
  logic             wr_tick, wr_soft, wr_sset, wr_sclr;
  logic             wr_pil, wr_state, wr_hpend, wr_htba, wr_hstate;
  logic [NUM_CMP-1:0] wr_cmp, hit;
  logic [CNT_W:0]   cmp_val [NUM_CMP];
  logic [CNT_W-1:0] tick_q;
  logic [HTBA_W-1:0] htba;
  logic [HST_W-1:0] hst;
  logic             ie_rise, pil_drop;
  logic [DATA_W-1:0] rd_mux;
  logic             recheck_d;

  // index decode
  always_comb begin
    idx_ok = 1'b1;
    case (reg_idx_e'(req_idx_i))
      IDX_TICK, IDX_SCMP, IDX_HCMP, IDX_SOFT, IDX_SSET, IDX_SCLR,
      IDX_PIL, IDX_STATE, IDX_HPEND, IDX_HTBA, IDX_HSTATE: idx_ok = 1'b1;
      IDX_HVER: idx_ok = !req_write_i;
      default:  idx_ok = 1'b0;
    endcase
  end

  assign wr_ok = req_valid_i && req_write_i && idx_ok;
  assign rd_ok = req_valid_i && !req_write_i && idx_ok;

  assign wr_tick   = wr_ok && (req_idx_i == IDX_TICK);
  assign wr_soft   = wr_ok && (req_idx_i == IDX_SOFT);
  assign wr_sset   = wr_ok && (req_idx_i == IDX_SSET);
  assign wr_sclr   = wr_ok && (req_idx_i == IDX_SCLR);
  assign wr_pil    = wr_ok && (req_idx_i == IDX_PIL);
  assign wr_state  = wr_ok && (req_idx_i == IDX_STATE);
  assign wr_hpend  = wr_ok && (req_idx_i == IDX_HPEND);
  assign wr_htba   = wr_ok && (req_idx_i == IDX_HTBA);
  assign wr_hstate = wr_ok && (req_idx_i == IDX_HSTATE);
  assign wr_cmp[CMP_SUP] = wr_ok && (req_idx_i == IDX_SCMP);
  assign wr_cmp[CMP_HYP] = wr_ok && (req_idx_i == IDX_HCMP);

  // free-running count
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      tick_q <= '0;
    else if (wr_tick) tick_q <= req_wdata_i[CNT_W-1:0];
    else              tick_q <= tick_q + 1'b1;
  end

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
    tirq_cmp #(.CNT_W(CNT_W)) u_cmp (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (wr_cmp[g]),
      .wdata_i (req_wdata_i),
      .cnt_i   (tick_q),
      .cmp_o   (cmp_val[g]),
      .hit_o   (hit[g])
    );
  end

  tirq_soft #(.SOFT_W(SOFT_W), .MATCH_BIT(MATCH_BIT)) u_soft (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_load_i (wr_soft),
    .wr_set_i  (wr_sset),
    .wr_clr_i  (wr_sclr),
    .wdata_i   (req_wdata_i[SOFT_W-1:0]),
    .match_i   (hit[CMP_SUP]),
    .soft_o    (softint_o)
  );

  tirq_priv #(
    .PIL_W(PIL_W), .HTBA_W(HTBA_W), .HST_W(HST_W), .HST_ID(HST_ID)
  ) u_priv (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_pil_i      (wr_pil),
    .wr_state_i    (wr_state),
    .wr_hpend_i    (wr_hpend),
    .wr_htba_i     (wr_htba),
    .wr_hstate_i   (wr_hstate),
    .pil_wdata_i   (req_wdata_i[PIL_W-1:0]),
    .ie_wdata_i    (req_wdata_i[IE_BIT]),
    .hpend_wdata_i (req_wdata_i[0]),
    .htba_wdata_i  (req_wdata_i[DATA_W-1:HTBA_LSB]),
    .hst_wdata_i   (req_wdata_i[HST_W-1:0]),
    .hmatch_i      (hit[CMP_HYP]),
    .pil_o         (pil_o),
    .ie_o          (ie_o),
    .hpend_o       (hpend_o),
    .htba_o        (htba),
    .hst_o         (hst),
    .ie_rise_o     (ie_rise),
    .pil_drop_o    (pil_drop)
  );

  always_comb begin
    rd_mux = '0;
    case (reg_idx_e'(req_idx_i))
      IDX_TICK:   rd_mux = DATA_W'(tick_q);
      IDX_SCMP:   rd_mux = DATA_W'(cmp_val[CMP_SUP]);
      IDX_HCMP:   rd_mux = DATA_W'(cmp_val[CMP_HYP]);
      IDX_SOFT, IDX_SSET, IDX_SCLR: rd_mux = DATA_W'(softint_o);
      IDX_PIL:    rd_mux = DATA_W'(pil_o);
      IDX_STATE:  rd_mux = DATA_W'(ie_o) << IE_BIT;
      IDX_HPEND:  rd_mux = DATA_W'(hpend_o);
      IDX_HVER:   rd_mux = HVER_VAL;
      IDX_HTBA:   rd_mux = {htba, {HTBA_LSB{1'b0}}};
      IDX_HSTATE: rd_mux = DATA_W'(hst);
      default:    rd_mux = '0;
    endcase
  end

  assign recheck_d = wr_soft || wr_sset || wr_sclr || ie_rise || pil_drop || (|hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o   <= '0;
      rvalid_o  <= 1'b0;
      err_o     <= 1'b0;
      recheck_o <= 1'b0;
    end else begin
      rvalid_o  <= rd_ok;
      err_o     <= req_valid_i && !idx_ok;
      recheck_o <= recheck_d;
      if (rd_ok) rdata_o <= rd_mux;
    end
  end
endmodule

// File: rtl/tick_irq_regs_chk.sv
module tick_irq_regs_chk #(
  parameter int unsigned DATA_W    = 64,
  parameter int unsigned SOFT_W    = 17,
  parameter int unsigned MATCH_BIT = 16,
  parameter int unsigned PIL_W     = 4,
  parameter int unsigned HTBA_LSB  = 15,
  parameter int unsigned HST_ID    = 11
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_write_i,
  input logic [4:0]        req_idx_i,
  input logic [DATA_W-1:0] req_wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              err_o,
  input logic              recheck_o,
  input logic [SOFT_W-1:0] softint_o,
  input logic              hpend_o,
  input logic [PIL_W-1:0]  pil_o,
  input logic [DATA_W-2:0] tick_q
);
  localparam int unsigned CNT_W = DATA_W - 1;

  logic wr_any, rd_any, tick_wr, hpend_wr;
  assign wr_any   = req_valid_i && req_write_i;
  assign rd_any   = req_valid_i && !req_write_i;
  assign tick_wr  = wr_any && (req_idx_i == 5'd0);
  assign hpend_wr = wr_any && (req_idx_i == 5'd8);

  // R1: count advances by one when not loaded
  a_r1_tick_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && !$past(tick_wr) |-> tick_q == CNT_W'($past(tick_q) + 1'b1));

  // R2: match bit rises only with a recheck pulse
  a_r2_match_bit_rechecks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(softint_o[MATCH_BIT]) |-> recheck_o);

  // R3: pending flag not set by software rises with recheck
  a_r3_hpend_rechecks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hpend_o) && !$past(hpend_wr) |-> recheck_o);

  // R8: lowering the level triggers re-evaluation
  a_r8_pil_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_any && (req_idx_i == 5'd6) && (req_wdata_i[PIL_W-1:0] < pil_o) |=> recheck_o);

  // R9: version word is not writable
  a_r9_hver_write_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_any && (req_idx_i == 5'd9) |=> err_o);

  // R10: trap base low bits read as zero
  a_r10_htba_low_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_any && (req_idx_i == 5'd10) |=> rdata_o[HTBA_LSB-1:0] == '0);

  // R11: id bit always set on read
  a_r11_hstate_id: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_any && (req_idx_i == 5'd11) |=> rdata_o[HST_ID]);

  // R12: unimplemented indices flag an error
  a_r12_bad_idx_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && (req_idx_i > 5'd11) |=> err_o);
endmodule

bind tick_irq_regs tick_irq_regs_chk #(
  .DATA_W(DATA_W), .SOFT_W(SOFT_W), .MATCH_BIT(MATCH_BIT),
  .PIL_W(PIL_W), .HTBA_LSB(HTBA_LSB), .HST_ID(HST_ID)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_write_i (req_write_i),
  .req_idx_i   (req_idx_i),
  .req_wdata_i (req_wdata_i),
  .rdata_o     (rdata_o),
  .err_o       (err_o),
  .recheck_o   (recheck_o),
  .softint_o   (softint_o),
  .hpend_o     (hpend_o),
  .pil_o       (pil_o),
  .tick_q      (tick_q)
);

// File: tb/tick_irq_regs_tb.sv
module tick_irq_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [4:0]  req_idx = '0;
  logic [63:0] req_wdata = '0;
  logic [63:0] rdata;
  logic        rvalid, err, recheck, hpend, ie;
  logic [16:0] softint;
  logic [3:0]  pil;

  int n_total = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  tick_irq_regs u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_write_i(req_write),
    .req_idx_i(req_idx), .req_wdata_i(req_wdata), .rdata_o(rdata), .rvalid_o(rvalid),
    .err_o(err), .recheck_o(recheck), .softint_o(softint), .hpend_o(hpend),
    .pil_o(pil), .ie_o(ie)
  );

  typedef struct packed {
    logic        wr;
    logic [4:0]  idx;
    logic [63:0] wdata;
    logic [63:0] exp;
    logic        exp_err;
    logic        exp_rc;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VT [NV] = '{
    '{1'b1, 5'd6,  64'd5,       64'd0,       1'b0, 1'b0}, // R8 raise level
    '{1'b0, 5'd6,  64'd0,       64'd5,       1'b0, 1'b0},
    '{1'b1, 5'd6,  64'd7,       64'd0,       1'b0, 1'b0},
    '{1'b1, 5'd6,  64'd2,       64'd0,       1'b0, 1'b1}, // R8 drop
    '{1'b0, 5'd6,  64'd0,       64'd2,       1'b0, 1'b0},
    '{1'b1, 5'd7,  64'd2,       64'd0,       1'b0, 1'b1}, // R7 enable rise
    '{1'b1, 5'd7,  64'd2,       64'd0,       1'b0, 1'b0}, // R7 already set
    '{1'b0, 5'd7,  64'd0,       64'd2,       1'b0, 1'b0},
    '{1'b1, 5'd7,  64'd0,       64'd0,       1'b0, 1'b0},
    '{1'b1, 5'd10, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 1'b0, 1'b0},
    '{1'b0, 5'd10, 64'd0,       64'hFFFF_FFFF_FFFF_8000, 1'b0, 1'b0}, // R10
    '{1'b1, 5'd11, 64'h0000_0000_0000_0123, 64'd0, 1'b0, 1'b0},
    '{1'b0, 5'd11, 64'd0,       64'h0000_0000_0000_0923, 1'b0, 1'b0}, // R11
    '{1'b1, 5'd3,  64'd0,       64'd0,       1'b0, 1'b1}, // R6 load
    '{1'b1, 5'd4,  64'h5,       64'd0,       1'b0, 1'b1}, // R6 set
    '{1'b0, 5'd3,  64'd0,       64'h5,       1'b0, 1'b0},
    '{1'b1, 5'd4,  64'h10000,   64'd0,       1'b0, 1'b1},
    '{1'b0, 5'd4,  64'd0,       64'h10005,   1'b0, 1'b0},
    '{1'b1, 5'd5,  64'h10001,   64'd0,       1'b0, 1'b1}, // R6 clear
    '{1'b0, 5'd5,  64'd0,       64'h4,       1'b0, 1'b0},
    '{1'b0, 5'd9,  64'd0,       64'h030608,  1'b0, 1'b0}, // R9
    '{1'b1, 5'd9,  64'hFFFF,    64'd0,       1'b1, 1'b0}, // R9 write error
    '{1'b0, 5'd9,  64'd0,       64'h030608,  1'b0, 1'b0},
    '{1'b1, 5'd20, 64'hFFFF,    64'd0,       1'b1, 1'b0}  // R12
  };

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // drive at a negedge, return at the negedge after the capturing edge
  task automatic op(logic w, logic [4:0] idx, logic [63:0] d);
    req_valid = 1'b1; req_write = w; req_idx = idx; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic waitn(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_total++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    waitn(3);
    rst_n = 1'b1;
    // R13 reset state
    check("R13 softint", 64'(softint), 64'd0);
    check("R13 pil", 64'(pil), 64'd0);
    check("R13 ie", 64'(ie), 64'd0);
    check("R13 hpend", 64'(hpend), 64'd0);
    check("R13 recheck", 64'(recheck), 64'd0);
    check("R13 err", 64'(err), 64'd0);
    op(1'b0, 5'd11, 64'd0);
    check("R11 hstate reset id", rdata, 64'h800);
    op(1'b0, 5'd1, 64'd0);
    check("R13 scmp reset disabled", rdata, 64'h8000_0000_0000_0000);

    for (int i = 0; i < NV; i++) begin
      op(VT[i].wr, VT[i].idx, VT[i].wdata);
      check($sformatf("vec%0d err", i), 64'(err), 64'(VT[i].exp_err));
      check($sformatf("vec%0d recheck", i), 64'(recheck), 64'(VT[i].exp_rc));
      if (!VT[i].wr) begin
        check($sformatf("vec%0d rvalid", i), 64'(rvalid), 64'd1);
        check($sformatf("vec%0d rdata", i), rdata, VT[i].exp);
      end
    end

    // R12 bad read flags error, state unchanged
    op(1'b0, 5'd31, 64'd0);
    check("R12 bad read err", 64'(err), 64'd1);
    check("R12 bad read rvalid", 64'(rvalid), 64'd0);
    op(1'b0, 5'd3, 64'd0);
    check("R12 softint unchanged", rdata, 64'h4);
    check("R12 pil unchanged", 64'(pil), 64'd2);

    // R1 load and count
    op(1'b1, 5'd0, 64'd50);
    op(1'b0, 5'd0, 64'd0);
    check("R1 tick after load", rdata, 64'd50);
    op(1'b0, 5'd0, 64'd0);
    check("R1 tick increments", rdata, 64'd51);

    // R2 supervisor match timing
    op(1'b1, 5'd0, 64'd100);
    op(1'b1, 5'd1, 64'd105);
    check("R2 no early bit", 64'(softint[16]), 64'd0);
    waitn(4);
    check("R2 not yet at count", 64'(softint[16]), 64'd0);
    check("R2 no early recheck", 64'(recheck), 64'd0);
    waitn(1);
    check("R2 match bit set", 64'(softint[16]), 64'd1);
    check("R2 match recheck", 64'(recheck), 64'd1);
    check("R2 other bits kept", 64'(softint[15:0]), 64'h4);
    waitn(1);
    check("R2 recheck one cycle", 64'(recheck), 64'd0);
    op(1'b1, 5'd5, 64'h10000);
    waitn(20);
    check("R2 fires once", 64'(softint[16]), 64'd0);

    // R5 equal value never arms
    op(1'b1, 5'd0, 64'd300);
    op(1'b1, 5'd1, 64'd300);
    op(1'b1, 5'd0, 64'd290);
    waitn(20);
    check("R5 equal not armed", 64'(softint[16]), 64'd0);

    // R4 cancel armed match
    op(1'b1, 5'd0, 64'd500);
    op(1'b1, 5'd1, 64'd510);
    op(1'b1, 5'd1, 64'h8000_0000_0000_01FE);
    waitn(20);
    check("R4 cancel", 64'(softint[16]), 64'd0);

    // R4 disabled hypervisor compare
    op(1'b1, 5'd0, 64'd600);
    op(1'b1, 5'd2, 64'h8000_0000_0000_025D);
    waitn(20);
    check("R4 hyp disabled", 64'(hpend), 64'd0);

    // R3 hypervisor match timing
    op(1'b1, 5'd0, 64'd700);
    op(1'b1, 5'd2, 64'd703);
    waitn(2);
    check("R3 not yet", 64'(hpend), 64'd0);
    waitn(1);
    check("R3 pending set", 64'(hpend), 64'd1);
    check("R3 recheck", 64'(recheck), 64'd1);
    op(1'b0, 5'd8, 64'd0);
    check("R3 pending read", rdata, 64'd1);
    op(1'b1, 5'd8, 64'd0);
    op(1'b0, 5'd8, 64'd0);
    check("R3 pending cleared", rdata, 64'd0);

    finish_run();
  end
endmodule